// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Sequencer

This block brings a frequency synthesizer out of reset over a write-only three-wire serial link made of a serial clock, a data line and a latch strobe. Each word is 24 bits long. The lowest three bits select which of eight target registers receives the word. The word is shifted out starting with its top bit. While the strobe is low the target samples the data line on every rising serial clock. When the strobe goes high again, the target commits the word to the selected register.

After reset the block plays a fixed power-up script of seventeen words without any help from outside. The loop filter needs time to discharge, so the block stops for a programmable number of system clocks after the second word. When the last word has been committed, the block raises `init_done`. From then on, the surrounding logic can request single frequency-update writes through `wr_req`/`wr_word`. A request is honoured only while `busy` is low. The serial clock is produced by dividing the system clock, and each half period lasts `SCLK_HALF` system cycles.

Top module: `synth_cfg_seq`

## Requirements
- R1: While reset is high, `le` is 1, `sclk` is 0 and `init_done` is 0.
- R2: Each word is sent top bit first. `sdata` changes only on the system-clock edge where `sclk` falls, or while `sclk` is low, so it holds steady whenever `sclk` is high.
- R3: Each frame contains exactly 24 rising `sclk` edges between the fall of `le` and its next rise.
- R4: `sclk` is low whenever `le` is high, and the rise of `le` ends the frame.
- R5: The script is 17 words in a fixed order. Word k (k = 0..16) is {21-bit payload 21'h0A000 + k, 3-bit register number 7 - (k mod 8)}, and the register number sits in bits [2:0].
- R6: Between the `le` rise of script word 1 and the `le` fall of script word 2 there are at least `SETTLE_CYCLES` system clocks.
- R7: `init_done` rises exactly one system clock after the `le` rise of script word 16, and it stays high until reset.
- R8: After `init_done`, a `wr_req` pulse seen while `busy` is low causes `wr_word` to be sent unchanged as the next frame.
- R9: A `wr_req` seen while `busy` is high, including any time before initialization finishes, is dropped and produces no frame.
- R10: `busy` is high for the whole initialization, and after an accepted request it stays high from the following cycle until `le` has gone high and its high half-period has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle request to send `wr_word` |
| wr_word | input | 24 | Word to send, with the register number in bits [2:0] |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data, top bit first |
| le | output | 1 | Latch strobe: low during a frame, rises to commit the word |
| busy | output | 1 | High while a request would be dropped |
| init_done | output | 1 | Power-up script complete |

## Verification
The hardest cases to reach are the windows where a request must be dropped. One is the long settle pause, which is silent on all serial lines. The other is the gap after the strobe has risen but before the shifter is idle again. The bench uses a short settle count and sends a request in the middle of the pause. After initialization it sends a second request while the first frame is still shifting. It then checks that the scoreboard receives only the words it expected and that every frame carries exactly 24 clocks. The settle length and the one-cycle `init_done` delay are measured by counting system clocks between strobe edges.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int WORD_W       = 24;
    localparam int ADDR_W       = 3;
    localparam int PAY_W        = WORD_W - ADDR_W;
    localparam int SCRIPT_LEN   = 17;
    localparam int SETTLE_AFTER = 1;       // pause follows this script index
    localparam int PAYLOAD_BASE = 'h0A000;

    typedef logic [WORD_W-1:0] cfg_word_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HIGH,
        SH_TAIL,
        SH_LATCH
    } shift_state_e;

    typedef enum logic [1:0] {
        SQ_ISSUE,
        SQ_WAIT,
        SQ_SETTLE,
        SQ_READY
    } seq_state_e;

    // Power-up word k: payload in the upper bits, register number in the low bits.
    function automatic cfg_word_t script_word(input int unsigned k);
        logic [PAY_W-1:0]  pay;
        logic [ADDR_W-1:0] reg_no;
        pay    = PAY_W'(PAYLOAD_BASE + k);
        reg_no = ADDR_W'((1 << ADDR_W) - 1 - (k % (1 << ADDR_W)));
        return {pay, reg_no};
    endfunction

endpackage

// File: rtl/cfg_sclk_div.sv
module cfg_sclk_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import synth_cfg_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  cfg_word_t word,
    output logic      busy,
    output logic      commit,
    output logic      done,
    output logic      sclk,
    output logic      sdata,
    output logic      le
);
    localparam int BW = $clog2(WORD_W);

    shift_state_e  state;
    cfg_word_t     sr;
    logic [BW-1:0] bitcnt;
    logic          tick;

    cfg_sclk_div #(.HALF(SCLK_HALF)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == SH_IDLE),
        .tick (tick)
    );

    assign busy  = (state != SH_IDLE);
    assign sdata = sr[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            sr     <= '0;
            bitcnt <= '0;
            sclk   <= 1'b0;
            le     <= 1'b1;
            commit <= 1'b0;
            done   <= 1'b0;
        end else begin
            commit <= 1'b0;
            done   <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        sr     <= word;
                        bitcnt <= '0;
                        le     <= 1'b0;
                        state  <= SH_SETUP;
                    end
                end
                SH_SETUP: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bitcnt == BW'(WORD_W - 1)) begin
                            state <= SH_TAIL;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            sr     <= sr << 1;
                            state  <= SH_SETUP;
                        end
                    end
                end
                SH_TAIL: begin
                    if (tick) begin
                        le     <= 1'b1;
                        commit <= 1'b1;
                        state  <= SH_LATCH;
                    end
                end
                SH_LATCH: begin
                    if (tick) begin
                        done  <= 1'b1;
                        state <= SH_IDLE;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R2: data line steady while the serial clock is high
    p_sdata_stable_r2: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdata));

    // R4: serial clock parked low whenever the strobe is high
    p_sclk_low_le_r4: assert property (@(posedge clk) disable iff (rst)
        le |-> !sclk);

    // R3: a commit only follows the full bit count
    p_full_word_r3: assert property (@(posedge clk) disable iff (rst)
        commit |-> (bitcnt == BW'(WORD_W - 1)));

endmodule

// File: rtl/cfg_script_seq.sv
module cfg_script_seq
    import synth_cfg_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_req,
    input  cfg_word_t wr_word,
    input  logic      shf_busy,
    input  logic      shf_commit,
    input  logic      shf_done,
    output logic      start,
    output cfg_word_t start_word,
    output logic      init_done,
    output logic      busy
);
    localparam int IW = $clog2(SCRIPT_LEN + 1);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);

    seq_state_e    state;
    logic [IW-1:0] idx;
    logic [SW-1:0] settle_cnt;

    assign busy = (state != SQ_READY) || shf_busy || start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_ISSUE;
            idx        <= '0;
            settle_cnt <= '0;
            start      <= 1'b0;
            start_word <= '0;
            init_done  <= 1'b0;
        end else begin
            start <= 1'b0;
            if (shf_commit && !init_done && idx == IW'(SCRIPT_LEN - 1)) begin
                init_done <= 1'b1;
            end
            case (state)
                SQ_ISSUE: begin
                    start      <= 1'b1;
                    start_word <= script_word(32'(idx));
                    state      <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (shf_done) begin
                        if (idx == IW'(SCRIPT_LEN - 1)) begin
                            state <= SQ_READY;
                        end else if (idx == IW'(SETTLE_AFTER)) begin
                            idx        <= idx + 1'b1;
                            settle_cnt <= '0;
                            state      <= SQ_SETTLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                SQ_SETTLE: begin
                    if (settle_cnt == SW'(SETTLE_CYCLES - 1)) begin
                        state <= SQ_ISSUE;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                SQ_READY: begin
                    if (wr_req && !shf_busy && !start) begin
                        start      <= 1'b1;
                        start_word <= wr_word;
                    end
                end
                default: state <= SQ_ISSUE;
            endcase
        end
    end

    // R7: ready flag never drops once raised
    p_init_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R9: a user word is launched only after the script completed
    p_accept_after_init_r9: assert property (@(posedge clk) disable iff (rst)
        (start && state == SQ_READY) |-> init_done);

    // R10: a launch never lands on an active shifter
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !shf_busy);

    // R6: serial lines stay quiet during the settle pause
    p_settle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SETTLE) |-> (!shf_busy && !start));

endmodule

// File: rtl/synth_cfg_seq.sv
module synth_cfg_seq
    import synth_cfg_pkg::*;
#(
    parameter int SCLK_HALF     = 4,
    parameter int SETTLE_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_word,
    output logic              sclk,
    output logic              sdata,
    output logic              le,
    output logic              busy,
    output logic              init_done
);
    logic      shf_busy;
    logic      shf_commit;
    logic      shf_done;
    logic      start;
    cfg_word_t start_word;

    cfg_script_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .wr_word    (wr_word),
        .shf_busy   (shf_busy),
        .shf_commit (shf_commit),
        .shf_done   (shf_done),
        .start      (start),
        .start_word (start_word),
        .init_done  (init_done),
        .busy       (busy)
    );

    cfg_shifter #(.SCLK_HALF(SCLK_HALF)) u_shf (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .word   (start_word),
        .busy   (shf_busy),
        .commit (shf_commit),
        .done   (shf_done),
        .sclk   (sclk),
        .sdata  (sdata),
        .le     (le)
    );

    // R1: idle line levels while reset is held
    p_reset_lines_r1: assert property (@(posedge clk)
        $past(rst) |-> (le && !sclk && !init_done));

endmodule

// File: tb/test_synth_cfg_seq.sv
module test_synth_cfg_seq;
    localparam int HALF   = 2;
    localparam int SETTLE = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 1'b0;
    logic [23:0] wr_word = '0;
    logic        sclk, sdata, le, busy, init_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [23:0] exp_q[$];
    logic [23:0] shreg = '0;
    int nbits = 0;
    int frames = 0;
    int rise1_cyc = 0;
    int fall2_cyc = 0;
    int sdata_bad = 0;
    int le_sclk_bad = 0;
    logic prev_sdata = 1'b0;

    synth_cfg_seq #(.SCLK_HALF(HALF), .SETTLE_CYCLES(SETTLE)) i_synth_cfg_seq (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_word(wr_word),
        .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .init_done(init_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Script word k per R5
    function automatic logic [23:0] exp_script(input int k);
        logic [20:0] pay;
        logic [2:0]  rn;
        pay = 21'(21'h0A000 + k);
        rn  = 3'(7 - (k % 8));
        return {pay, rn};
    endfunction

    // Target model: shift on rising serial clock while the strobe is low
    always @(posedge sclk) begin
        if (!le) begin
            shreg = {shreg[22:0], sdata};
            nbits++;
        end
    end

    always @(negedge le) begin
        nbits = 0;
        if (frames == 2) fall2_cyc = cyc;
    end

    // Scoreboard monitor: each commit pops the next expected word
    always @(posedge le) begin
        if (!rst) begin
            chk(nbits == 24, "R3 clocks per frame", nbits, 24);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected frame", shreg, 0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk(shreg == e, "R2/R5/R8 word content", shreg, e);
            end
            frames++;
            if (frames == 2) rise1_cyc = cyc;
        end
    end

    // Line-level watcher sampled between edges
    always @(negedge clk) begin
        if (!rst) begin
            if (sclk && sdata != prev_sdata) sdata_bad++;
            if (le && sclk) le_sclk_bad++;
        end
        prev_sdata = sdata;
    end

    task automatic request(input logic [23:0] w, input bit expect_accept);
        @(negedge clk);
        if (expect_accept) begin
            chk(busy == 1'b0, "R8 busy low before request", busy, 0);
            exp_q.push_back(w);
        end else begin
            chk(busy == 1'b1, "R9 busy high at dropped request", busy, 1);
        end
        wr_req  = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_req  = 1'b0;
        wr_word = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 17; k++) exp_q.push_back(exp_script(k));

        repeat (4) @(negedge clk);
        chk(le == 1'b1, "R1 le in reset", le, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(init_done == 1'b0, "R1 init_done in reset", init_done, 0);
        rst = 1'b0;

        // Drop a request in the middle of the settle pause
        wait (frames == 2);
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R10 busy during settle", busy, 1);
        chk(init_done == 1'b0, "R9 not ready during settle", init_done, 0);
        request(24'hBADBA5, 1'b0);

        wait (frames == 17);
        @(negedge clk);
        chk(init_done == 1'b0, "R7 init_done at le rise", init_done, 0);
        chk(busy == 1'b1, "R10 busy through final strobe", busy, 1);
        @(negedge clk);
        chk(init_done == 1'b1, "R7 init_done one clock later", init_done, 1);
        chk(fall2_cyc - rise1_cyc >= SETTLE, "R6 settle length",
            fall2_cyc - rise1_cyc, SETTLE);

        wait_idle();
        request(24'h5A5A53, 1'b1);
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        repeat (6) @(negedge clk);
        request(24'h123456, 1'b0);

        wait (frames == 18);
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy during strobe high", busy, 1);
        wait_idle();
        chk(init_done == 1'b1, "R7 init_done held", init_done, 1);

        request(24'hC3F0A2, 1'b1);
        wait (frames == 19);
        wait_idle();
        repeat (20) @(negedge clk);

        chk(frames == 19, "R9 frame count", frames, 19);
        chk(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
        chk(sdata_bad == 0, "R2 sdata steady while sclk high", sdata_bad, 0);
        chk(le_sclk_bad == 0, "R4 sclk low while le high", le_sclk_bad, 0);
        finish_run();
    end
endmodule